// File: doc/BRIEF.md
# Flywheel Frame Synchronisation Tracker

This block follows a sync-word correlator in a serial telemetry receiver. The block runs on the bit clock. Each cycle it takes the correlator's single-cycle detect flag and the terminal value of a free-running frame counter (the flywheel). From these it decides whether frame alignment is being searched for, is being confirmed, is held, or is in doubt. The frame length is a runtime input, so one instance can follow several data formats. Examples are 19200-, 33600- or 37249-bit frames, which need terminal values of 19199, 33599 or 37248.

In the search mode every bit position is a candidate. The first detect realigns the counter and starts a confirmation step. A second detect, exactly one frame later, declares lock. Once locked, the tracker rides through one missing sync word and keeps its alignment. It gives up only when two expected sync words in a row are absent. Each expected-but-absent sync word is reported on a loss strobe. Each frame boundary seen while aligned is reported on a frame-start strobe.

Top module: `fsync_tracker`

## Requirements
- R1: While reset is high at a clock edge, the outputs become mode 0, count 0, and both strobes low. The mode codes are: 0 search, 1 verify, 2 lock, 3 check.
- R2: The count goes from 0 up to the terminal value, then returns to 0 on the next cycle, so that one frame spans terminal+1 cycles. The only exceptions are the reloads in R3 and R10.
- R3: In search, a detect on any cycle moves the mode to verify and sets the count to 0 on the next cycle. With no detect, the mode stays in search.
- R4: In verify, a detect in the cycle where the count equals the terminal value moves the mode to lock. If there is no detect in that cycle, the mode returns to search.
- R5: In lock, a missing detect at the terminal value moves the mode to check. A detect there keeps the mode in lock.
- R6: In check, a detect at the terminal value moves the mode back to lock. A second missing detect returns the mode to search.
- R7: In verify, lock and check, a detect on a cycle whose count differs from the terminal value changes neither the mode nor the count.
- R8: The loss strobe is high for exactly the one cycle after a terminal-value cycle with no detect, in verify, lock or check. It is never raised after a search-mode cycle.
- R9: The frame-start strobe is high for the one cycle after each terminal-value cycle spent in lock or check. At no other time is it high.
- R10: A cycle in which the terminal-value input differs from the value used on the previous cycle forces search mode and count 0 on the next cycle, with both strobes low. This takes priority over any detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_det | input | 1 | Correlator detect flag, one cycle per detection |
| frame_term | input | CNT_W | Terminal count, equal to frame length minus one |
| mode | output | 2 | Tracker mode: 0 search, 1 verify, 2 lock, 3 check |
| loss_pulse | output | 1 | One-cycle strobe for an expected sync word that was missing |
| frame_start | output | 1 | One-cycle strobe at each frame boundary while aligned |
| fw_count | output | CNT_W | Current flywheel count |

## Verification
The assertions take for granted that the terminal-value input is never below 1 and stays put for at least one cycle after it changes. Under that condition, a stable input equals the value the tracker holds internally. The counter-step and check-exit properties depend on this. The stimulus uses terminal values from 2 to 9 and changes the value only between runs that each last several frames. One directed change is made mid-frame to exercise the resync rule. Detects are drawn densely at the expected positions and sparsely elsewhere, so every mode sees both hits and misses as well as off-position detects.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  typedef enum logic [1:0] {
    MODE_SEARCH = 2'd0,
    MODE_VERIFY = 2'd1,
    MODE_LOCK   = 2'd2,
    MODE_CHECK  = 2'd3
  } fsync_mode_e;

endpackage

// File: rtl/fsync_len_guard.sv
// Holds the terminal value in use and flags a cycle where the input differs.
module fsync_len_guard #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] term_in,
  output logic [CNT_W-1:0] term_q,
  output logic             len_change
);

  always_ff @(posedge clk) begin
    term_q <= term_in;
  end

  // Reset loads the input too, so no change is flagged right after reset.
  assign len_change = !rst && (term_in != term_q);

endmodule

// File: rtl/fsync_flywheel.sv
// Free-running frame counter, wraps at the held terminal value.
module fsync_flywheel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] term,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt,
  output logic             at_term
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  assign at_term = (cnt == term);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (reload)  cnt <= '0;
    else if (at_term) cnt <= '0;
    else              cnt <= cnt + STEP;
  end

endmodule

// File: rtl/fsync_mode_fsm.sv
// Search / verify / lock / check sequencing with registered strobes.
module fsync_mode_fsm
  import fsync_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        raw_det,
  input  logic        at_term,
  input  logic        len_change,
  output fsync_mode_e mode_q,
  output logic        reload,
  output logic        loss_q,
  output logic        fs_q
);

  fsync_mode_e mode_d;
  logic        loss_d;
  logic        fs_d;

  assign reload = len_change || ((mode_q == MODE_SEARCH) && raw_det);

  always_comb begin
    mode_d = mode_q;
    loss_d = 1'b0;
    fs_d   = 1'b0;
    if (len_change) begin
      mode_d = MODE_SEARCH;
    end else begin
      unique case (mode_q)
        MODE_SEARCH: begin
          if (raw_det) mode_d = MODE_VERIFY;
        end
        MODE_VERIFY: begin
          if (at_term) begin
            if (raw_det) begin
              mode_d = MODE_LOCK;
            end else begin
              mode_d = MODE_SEARCH;
              loss_d = 1'b1;
            end
          end
        end
        MODE_LOCK: begin
          if (at_term) begin
            fs_d = 1'b1;
            if (!raw_det) begin
              mode_d = MODE_CHECK;
              loss_d = 1'b1;
            end
          end
        end
        MODE_CHECK: begin
          if (at_term) begin
            fs_d = 1'b1;
            if (raw_det) begin
              mode_d = MODE_LOCK;
            end else begin
              mode_d = MODE_SEARCH;
              loss_d = 1'b1;
            end
          end
        end
        default: mode_d = MODE_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SEARCH;
      loss_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      loss_q <= loss_d;
      fs_q   <= fs_d;
    end
  end

endmodule

// File: rtl/fsync_tracker.sv
module fsync_tracker
  import fsync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_det,
  input  logic [CNT_W-1:0] frame_term,
  output logic [1:0]       mode,
  output logic             loss_pulse,
  output logic             frame_start,
  output logic [CNT_W-1:0] fw_count
);

  logic [CNT_W-1:0] term_q;
  logic             len_change;
  logic             reload;
  logic             at_term;
  fsync_mode_e      mode_q;

  fsync_len_guard #(.CNT_W(CNT_W)) u_guard (
    .clk        (clk),
    .rst        (rst),
    .term_in    (frame_term),
    .term_q     (term_q),
    .len_change (len_change)
  );

  fsync_flywheel #(.CNT_W(CNT_W)) u_fly (
    .clk     (clk),
    .rst     (rst),
    .term    (term_q),
    .reload  (reload),
    .cnt     (fw_count),
    .at_term (at_term)
  );

  fsync_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .raw_det    (raw_det),
    .at_term    (at_term),
    .len_change (len_change),
    .mode_q     (mode_q),
    .reload     (reload),
    .loss_q     (loss_pulse),
    .fs_q       (frame_start)
  );

  assign mode = mode_q;

endmodule

// File: rtl/fsync_tracker_chk.sv
module fsync_tracker_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             raw_det,
  input logic [CNT_W-1:0] frame_term,
  input logic [1:0]       mode,
  input logic             loss_pulse,
  input logic             frame_start,
  input logic [CNT_W-1:0] fw_count
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mode == 2'd0 && fw_count == '0 && !loss_pulse && !frame_start));

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (fw_count == frame_term) |=> (fw_count == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (fw_count != frame_term && $stable(frame_term) && !(mode == 2'd0 && raw_det))
    |=> (fw_count == $past(fw_count) + 1'b1));

  p_search_det_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && raw_det && $stable(frame_term)) |=> (mode == 2'd1 && fw_count == '0));

  p_lock_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && $past(mode) != 2'd2) |-> ($past(mode) == 2'd1 || $past(mode) == 2'd3));

  p_check_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && fw_count == frame_term && !raw_det && $stable(frame_term))
    |=> (mode == 2'd0 && loss_pulse));

  p_no_loss_search_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> !loss_pulse);

  p_fs_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ($past(mode) == 2'd2 || $past(mode) == 2'd3));

  p_len_change_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_term != $past(frame_term)) |=> (mode == 2'd0 && fw_count == '0 && !loss_pulse));

endmodule

bind fsync_tracker fsync_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .raw_det     (raw_det),
  .frame_term  (frame_term),
  .mode        (mode),
  .loss_pulse  (loss_pulse),
  .frame_start (frame_start),
  .fw_count    (fw_count)
);

// File: tb/tb_fsync_tracker.sv
module tb_fsync_tracker;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             raw_det = 1'b0;
  logic [CNT_W-1:0] frame_term = 16'd7;
  logic [1:0]       mode;
  logic             loss_pulse;
  logic             frame_start;
  logic [CNT_W-1:0] fw_count;

  fsync_tracker #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .raw_det(raw_det), .frame_term(frame_term),
    .mode(mode), .loss_pulse(loss_pulse), .frame_start(frame_start),
    .fw_count(fw_count)
  );

  always #5 clk = ~clk;

  int n_total = 0;
  int n_pass  = 0;
  bit done    = 1'b0;

  // expected state built from the requirements
  logic [1:0]       m_mode = 2'd0;
  logic [CNT_W-1:0] m_cnt  = '0;
  logic [CNT_W-1:0] m_term = 16'd7;
  logic             m_loss = 1'b0;
  logic             m_fs   = 1'b0;
  logic [15:0]      lfsr   = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  // Called just after a falling edge: drive, predict, clock, compare.
  task automatic step(input logic rd, input logic [CNT_W-1:0] t, input string tag);
    logic tc;
    raw_det    = rd;
    frame_term = t;
    m_loss = 1'b0;
    m_fs   = 1'b0;
    if (t != m_term) begin
      m_term = t;
      m_cnt  = '0;
      m_mode = 2'd0;
    end else begin
      tc = (m_cnt == m_term);
      if (m_mode == 2'd0) begin
        if (rd) begin m_mode = 2'd1; m_cnt = '0; end
        else m_cnt = tc ? '0 : m_cnt + 1'b1;
      end else begin
        m_cnt = tc ? '0 : m_cnt + 1'b1;
        if (tc) begin
          m_fs = (m_mode == 2'd2 || m_mode == 2'd3);
          case (m_mode)
            2'd1: if (rd) m_mode = 2'd2; else begin m_mode = 2'd0; m_loss = 1'b1; end
            2'd2: if (!rd) begin m_mode = 2'd3; m_loss = 1'b1; end
            default: if (rd) m_mode = 2'd2; else begin m_mode = 2'd0; m_loss = 1'b1; end
          endcase
        end
      end
    end
    @(posedge clk);
    #1;
    chk(mode == m_mode, tag, "mode", mode, m_mode);
    chk(fw_count == m_cnt, tag, "count", fw_count, m_cnt);
    chk(loss_pulse == m_loss, tag, "loss", loss_pulse, m_loss);
    chk(frame_start == m_fs, tag, "frame_start", frame_start, m_fs);
    @(negedge clk);
  endtask

  // idle (or off-position detects) until the count sits at the terminal value
  task automatic run_to_term(input logic rd_off, input string tag);
    while (m_cnt != m_term) step(rd_off, m_term, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(mode == 2'd0 && fw_count == '0 && !loss_pulse && !frame_start, "R1",
        "reset state", {mode, fw_count}, 0);
    @(negedge clk);
    rst = 1'b0;

    // directed walk through every mode, terminal 7 (8-cycle frame)
    step(1'b0, 16'd7, "R3");
    step(1'b0, 16'd7, "R3");
    step(1'b1, 16'd7, "R3");          // search -> verify, count reloads
    run_to_term(1'b0, "R2");
    step(1'b1, 16'd7, "R4");          // verify -> lock
    run_to_term(1'b1, "R7");          // off-position detects ignored
    step(1'b1, 16'd7, "R9");          // lock hit, frame start
    run_to_term(1'b0, "R2");
    step(1'b0, 16'd7, "R5");          // lock miss -> check, loss
    run_to_term(1'b1, "R7");
    step(1'b1, 16'd7, "R6");          // check hit -> lock
    run_to_term(1'b0, "R2");
    step(1'b0, 16'd7, "R5");          // -> check
    run_to_term(1'b0, "R2");
    step(1'b0, 16'd7, "R6");          // second miss -> search
    for (int i = 0; i < 20; i++) step(1'b0, 16'd7, "R8");   // search wraps, no loss
    step(1'b1, 16'd7, "R3");
    run_to_term(1'b0, "R2");
    step(1'b0, 16'd7, "R4");          // verify miss -> search, loss
    step(1'b1, 16'd7, "R3");
    step(1'b0, 16'd7, "R2");
    step(1'b1, 16'd5, "R10");         // mid-frame length change wins over detect
    step(1'b0, 16'd5, "R10");

    // sweep over terminal values with pseudo-random detects
    for (int t = 2; t <= 9; t++) begin
      for (int c = 0; c < 400; c++) begin
        logic rd;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (m_mode != 2'd0 && m_cnt == m_term && m_term == 16'(t)) rd = (lfsr[1:0] != 2'b00);
        else rd = (lfsr[4:0] == 5'd0);
        step(rd, 16'(t), (c == 0) ? "R10" : "R7");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

endmodule